// File: doc/BRIEF.md
# Energy Pulse Output Generator

This block turns three streams of signed per-sample power values (active, apparent and reactive) into active-low pulse trains whose rate follows the energy accumulated on each stream. Every stream has its own signed accumulator. A sample strobe adds the incoming power. Whenever the accumulator's magnitude reaches a programmable threshold, a pulse is issued and one threshold is removed in the direction of the accumulated energy. All timing is expressed in master-clock cycles, so the whole pulse schedule scales with that clock.

The first output carries active-energy pulses. The second carries apparent-energy pulses, or, when a mode bit is set, a level that shows the direction of the active energy. The third carries reactive-energy pulses. Pulse width and minimum pulse period are fixed cycle counts. When energy arrives faster than the minimum period allows, the surplus stays in the accumulator and drains at the highest permitted rate. Two ordering rules apply. The direction level must be stable for a set number of cycles before the first or third output falls. The third output may fall only a set number of cycles after the first output's most recent falling edge.

Top module: `energy_pulse_gen`

## Requirements
- R1: A synchronous reset clears all three accumulators, drives `e1_n`, `e2_n` and `e3_n` high, and sets the direction level to high (positive).
- R2: With `smp_vld` high, each channel adds its power input to its accumulator. When the accumulator magnitude is at least `threshold`, the channel pulses once and the threshold is removed. The total number of pulses equals the integer part of |total energy| / `threshold`.
- R3: Each pulse holds its output low for exactly `PW_CYC` cycles.
- R4: Two successive falling edges on one output are never less than `PER_CYC` cycles apart. Energy that arrives faster is kept in the accumulator and comes out as pulses spaced exactly `PER_CYC` apart.
- R5: Negative accumulated energy also produces pulses. Each such pulse adds one threshold back toward zero.
- R6: With `e2_sign_mode` = 0, `e2_n` carries apparent-energy pulses. With `e2_sign_mode` = 1, `e2_n` is a level: 1 means the pending active pulse is positive, 0 means it is negative.
- R7: In sign mode, the direction level is stable for at least `SETUP_CYC` cycles before any falling edge of `e1_n` or `e3_n`. A pulse whose direction differs from the level first flips the level and then waits.
- R8: A falling edge of `e3_n` comes at least `LAG_CYC` cycles after the latest falling edge of `e1_n`, and never in the same cycle.
- R9: A `threshold` of zero produces no pulses on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous active-high reset |
| smp_vld | input | 1 | new power sample strobe |
| pwr_act | input | P_W | signed active power sample |
| pwr_app | input | P_W | signed apparent power sample |
| pwr_rea | input | P_W | signed reactive power sample |
| threshold | input | TH_W | energy per pulse, unsigned |
| e2_sign_mode | input | 1 | 1: second output shows energy direction |
| e1_n | output | 1 | active-energy pulses, active low |
| e2_n | output | 1 | apparent pulses or direction level |
| e3_n | output | 1 | reactive-energy pulses, active low |

## Verification
The bench drives bursts that request pulses faster than the minimum period. A design that dropped the surplus would show too few falling edges, and one that ignored the period would space them too closely. Negative-energy bursts catch a design that compares the signed value instead of its magnitude, because such a design would stay silent. In sign mode, a direction reversal is forced while a pulse is already pending. A design that flipped the level and fired in the same cycle would break the settle gap. Simultaneous active and reactive bursts expose a third output that falls too soon after the first, and a zero threshold exposes endless pulsing.

// File: rtl/epg_pkg.sv
package epg_pkg;

    localparam int NCH = 3;

    typedef enum logic [1:0] {
        CH_ACT = 2'd0,
        CH_APP = 2'd1,
        CH_REA = 2'd2
    } ch_e;

    typedef struct packed {
        logic pend;
        logic neg;
    } req_t;

    function automatic logic gate_fire(input req_t r, input logic ready, input logic allow);
        return r.pend && ready && allow;
    endfunction

    function automatic logic dir_mismatch(input req_t r, input logic level_pos);
        return r.pend && (r.neg == level_pos);
    endfunction

endpackage

// File: rtl/epg_accum.sv
module epg_accum
    import epg_pkg::*;
#(
    parameter int P_W   = 16,
    parameter int TH_W  = 20,
    parameter int ACC_W = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   add_en,
    input  logic signed [P_W-1:0]  pwr,
    input  logic        [TH_W-1:0] thr,
    input  logic                   fire,
    output req_t                   req
);
    localparam int SW = ACC_W + 1;

    logic signed [ACC_W-1:0] acc;
    logic signed [SW-1:0]    acc_x, add_x, thr_x, step_x, sum_x, mag_x;

    always_comb begin
        acc_x  = {acc[ACC_W-1], acc};
        add_x  = add_en ? {{(SW-P_W){pwr[P_W-1]}}, pwr} : '0;
        thr_x  = {{(SW-TH_W){1'b0}}, thr};
        mag_x  = acc[ACC_W-1] ? -acc_x : acc_x;
        step_x = '0;
        if (fire) step_x = acc[ACC_W-1] ? -thr_x : thr_x;
        sum_x  = acc_x + add_x - step_x;
        req.neg  = acc[ACC_W-1];
        req.pend = (thr != '0) && (mag_x >= thr_x);
    end

    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else     acc <= sum_x[ACC_W-1:0];
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        sum_x[SW-1] == sum_x[SW-2]);

endmodule

// File: rtl/epg_timer.sv
module epg_timer #(
    parameter int PER_CYC = 1024,
    parameter int PW_CYC  = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic ready,
    output logic out_n
);
    localparam int T_W     = $clog2(PER_CYC);
    localparam int LOW_MIN = PER_CYC - PW_CYC;

    logic [T_W-1:0] t;

    always_ff @(posedge clk) begin
        if (rst)          t <= '0;
        else if (fire)    t <= T_W'(PER_CYC - 1);
        else if (t != '0) t <= t - 1'b1;
    end

    assign ready = (t == '0);
    assign out_n = !(t >= T_W'(LOW_MIN));

    p_fire_ready_r4: assert property (@(posedge clk) disable iff (rst)
        fire |-> t == '0);

    p_low_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!out_n && t != T_W'(LOW_MIN)) |=> !out_n);

endmodule

// File: rtl/epg_seq.sv
module epg_seq
    import epg_pkg::*;
#(
    parameter int SETUP_CYC = 6,
    parameter int LAG_CYC   = 1016
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sign_mode,
    input  req_t           req   [NCH],
    input  logic [NCH-1:0] ready,
    output logic [NCH-1:0] fire,
    output logic           sign_lvl
);
    localparam int A_W = $clog2(SETUP_CYC + 1);
    localparam int L_W = $clog2(LAG_CYC);

    logic           sign_q;
    logic [A_W-1:0] age;
    logic [L_W-1:0] lag;
    logic           flip, settled;

    always_comb begin
        flip    = sign_mode && dir_mismatch(req[CH_ACT], sign_q);
        settled = !sign_mode || ((age == A_W'(SETUP_CYC)) && !flip);
        fire[CH_ACT] = gate_fire(req[CH_ACT], ready[CH_ACT], settled);
        fire[CH_APP] = gate_fire(req[CH_APP], ready[CH_APP], 1'b1);
        fire[CH_REA] = gate_fire(req[CH_REA], ready[CH_REA],
                                 settled && (lag == '0) && !fire[CH_ACT]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sign_q <= 1'b1;
            age    <= A_W'(SETUP_CYC);
            lag    <= '0;
        end else begin
            if (flip) begin
                sign_q <= !sign_q;
                age    <= '0;
            end else if (age != A_W'(SETUP_CYC)) begin
                age <= age + 1'b1;
            end
            if (fire[CH_ACT])   lag <= L_W'(LAG_CYC - 1);
            else if (lag != '0) lag <= lag - 1'b1;
        end
    end

    assign sign_lvl = sign_q;

    p_e3_not_with_e1_r8: assert property (@(posedge clk) disable iff (rst)
        fire[CH_REA] |-> !fire[CH_ACT]);

endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen
    import epg_pkg::*;
#(
    parameter int P_W       = 16,
    parameter int TH_W      = 20,
    parameter int ACC_W     = 24,
    parameter int PER_CYC   = 1024,
    parameter int PW_CYC    = 1000,
    parameter int SETUP_CYC = 6,
    parameter int LAG_CYC   = 1016
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   smp_vld,
    input  logic signed [P_W-1:0]  pwr_act,
    input  logic signed [P_W-1:0]  pwr_app,
    input  logic signed [P_W-1:0]  pwr_rea,
    input  logic        [TH_W-1:0] threshold,
    input  logic                   e2_sign_mode,
    output logic                   e1_n,
    output logic                   e2_n,
    output logic                   e3_n
);
    localparam int G_W = $clog2(LAG_CYC + SETUP_CYC + 2);

    logic signed [P_W-1:0] pwr_v [NCH];
    req_t                  req_v [NCH];
    logic [NCH-1:0]        ready_v, fire_v, out_v;
    logic                  sign_lvl;

    assign pwr_v[CH_ACT] = pwr_act;
    assign pwr_v[CH_APP] = pwr_app;
    assign pwr_v[CH_REA] = pwr_rea;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        epg_accum #(.P_W(P_W), .TH_W(TH_W), .ACC_W(ACC_W)) u_acc (
            .clk(clk), .rst(rst), .add_en(smp_vld), .pwr(pwr_v[c]),
            .thr(threshold), .fire(fire_v[c]), .req(req_v[c]));
        epg_timer #(.PER_CYC(PER_CYC), .PW_CYC(PW_CYC)) u_tmr (
            .clk(clk), .rst(rst), .fire(fire_v[c]),
            .ready(ready_v[c]), .out_n(out_v[c]));
    end

    epg_seq #(.SETUP_CYC(SETUP_CYC), .LAG_CYC(LAG_CYC)) u_seq (
        .clk(clk), .rst(rst), .sign_mode(e2_sign_mode), .req(req_v),
        .ready(ready_v), .fire(fire_v), .sign_lvl(sign_lvl));

    assign e1_n = out_v[CH_ACT];
    assign e2_n = e2_sign_mode ? sign_lvl : out_v[CH_APP];
    assign e3_n = out_v[CH_REA];

    // Ordering checkers: distances measured from the outputs themselves.
    logic [G_W-1:0] since_e1, since_sign;
    logic           e1_prev, sign_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_e1   <= G_W'(LAG_CYC);
            since_sign <= G_W'(SETUP_CYC);
            e1_prev    <= 1'b1;
            sign_prev  <= 1'b1;
        end else begin
            e1_prev   <= e1_n;
            sign_prev <= sign_lvl;
            if (e1_prev && !e1_n)              since_e1 <= G_W'(1);
            else if (since_e1 != G_W'(LAG_CYC)) since_e1 <= since_e1 + 1'b1;
            if (sign_prev != sign_lvl)             since_sign <= G_W'(1);
            else if (since_sign != G_W'(SETUP_CYC)) since_sign <= since_sign + 1'b1;
        end
    end

    p_reset_high_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (e1_n && e2_n && e3_n));

    p_e3_lag_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(e3_n) |-> (since_e1 >= G_W'(LAG_CYC)));

    p_sign_settle_r7: assert property (@(posedge clk) disable iff (rst)
        (e2_sign_mode && ($fell(e1_n) || $fell(e3_n))) |->
            (sign_prev == sign_lvl && since_sign >= G_W'(SETUP_CYC)));

endmodule

// File: tb/energy_pulse_gen_bench.sv
module energy_pulse_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P_W = 16, TH_W = 20, ACC_W = 24;
    localparam int PER = 1024, PW = 1000, SETUP = 6, LAG = 1016;
    localparam int BIG = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_vld = 1'b0;
    logic signed [P_W-1:0] pwr_act = '0, pwr_app = '0, pwr_rea = '0;
    logic [TH_W-1:0] threshold = 20'd1000;
    logic e2_sign_mode = 1'b0;
    logic e1_n, e2_n, e3_n;

    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    energy_pulse_gen u_energy_pulse_gen (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .pwr_act(pwr_act),
        .pwr_app(pwr_app), .pwr_rea(pwr_rea), .threshold(threshold),
        .e2_sign_mode(e2_sign_mode), .e1_n(e1_n), .e2_n(e2_n), .e3_n(e3_n));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model: cycles since each fall, integer accumulators.
    int  m_acc [3];
    int  m_sf  [3];
    int  m_se1, m_ss;
    bit  m_sgn;

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 3; c++) begin m_acc[c] = 0; m_sf[c] = BIG; end
            m_se1 = BIG; m_ss = BIG; m_sgn = 1;
        end else begin
            bit pend [3];
            bit f [3];
            bit flip, settled;
            int th, p [3];
            th = int'(threshold);
            p[0] = int'(pwr_act); p[1] = int'(pwr_app); p[2] = int'(pwr_rea);
            for (int c = 0; c < 3; c++)
                pend[c] = (th != 0) && ((m_acc[c] < 0 ? -m_acc[c] : m_acc[c]) >= th);
            flip    = e2_sign_mode && pend[0] && ((m_acc[0] < 0) == m_sgn);
            settled = !e2_sign_mode || (m_ss >= SETUP && !flip);
            f[0] = pend[0] && m_sf[0] >= PER-1 && settled;
            f[1] = pend[1] && m_sf[1] >= PER-1;
            f[2] = pend[2] && m_sf[2] >= PER-1 && m_se1 >= LAG-1 && !f[0] && settled;
            for (int c = 0; c < 3; c++) begin
                int step;
                step = f[c] ? (m_acc[c] < 0 ? -th : th) : 0;
                m_acc[c] = m_acc[c] + (smp_vld ? p[c] : 0) - step;
                if (f[c]) m_sf[c] = 0; else if (m_sf[c] < BIG) m_sf[c]++;
            end
            if (f[0]) m_se1 = 0; else if (m_se1 < BIG) m_se1++;
            if (flip) begin m_sgn = !m_sgn; m_ss = 0; end
            else if (m_ss < BIG) m_ss++;
        end
    end

    // Cycle compare and edge statistics on the falling clock edge.
    int  cyc = 0;
    bit  p1 = 1, p2 = 1, p3 = 1;
    int  n_fall [3];
    int  last_fall [3];
    int  min_sp [3];
    int  min_w, max_w;
    int  min_e3gap, min_sgap, last_e2chg;

    task automatic clear_stats();
        for (int c = 0; c < 3; c++) begin n_fall[c] = 0; last_fall[c] = -BIG; min_sp[c] = BIG; end
        min_w = BIG; max_w = 0; min_e3gap = BIG; min_sgap = BIG; last_e2chg = -BIG;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            bit e1m, e2m, e3m;
            e1m = !(m_sf[0] < PW);
            e2m = e2_sign_mode ? m_sgn : !(m_sf[1] < PW);
            e3m = !(m_sf[2] < PW);
            check(e1_n === e1m, "R2 e1_n vs model", e1_n, e1m);
            check(e2_n === e2m, "R6 e2_n vs model", e2_n, e2m);
            check(e3_n === e3m, "R8 e3_n vs model", e3_n, e3m);
            if (p1 && !e1_n) begin
                if (cyc - last_fall[0] < min_sp[0]) min_sp[0] = cyc - last_fall[0];
                last_fall[0] = cyc; n_fall[0]++;
                if (e2_sign_mode && cyc - last_e2chg < min_sgap) min_sgap = cyc - last_e2chg;
            end
            if (!p1 && e1_n) begin
                if (cyc - last_fall[0] < min_w) min_w = cyc - last_fall[0];
                if (cyc - last_fall[0] > max_w) max_w = cyc - last_fall[0];
            end
            if (p2 != e2_n) last_e2chg = cyc;
            if (!e2_sign_mode && p2 && !e2_n) begin
                if (cyc - last_fall[1] < min_sp[1]) min_sp[1] = cyc - last_fall[1];
                last_fall[1] = cyc; n_fall[1]++;
            end
            if (p3 && !e3_n) begin
                if (cyc - last_fall[0] < min_e3gap) min_e3gap = cyc - last_fall[0];
                if (e2_sign_mode && cyc - last_e2chg < min_sgap) min_sgap = cyc - last_e2chg;
                last_fall[2] = cyc; n_fall[2]++;
            end
        end
        p1 = e1_n; p2 = e2_n; p3 = e3_n;
    end

    task automatic do_reset(input bit mode, input int th);
        @(negedge clk);
        rst = 1; e2_sign_mode = mode; threshold = TH_W'(th); smp_vld = 0;
        repeat (3) @(negedge clk);
        check(e1_n && e2_n && e3_n, "R1 outputs high in reset", {e1_n, e2_n, e3_n}, 7);
        rst = 0;
        clear_stats();
    endtask

    task automatic burst(input int a, input int ap, input int r, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_vld = 1; pwr_act = P_W'(a); pwr_app = P_W'(ap); pwr_rea = P_W'(r);
        end
        @(negedge clk);
        smp_vld = 0; pwr_act = '0; pwr_app = '0; pwr_rea = '0;
    endtask

    initial begin
        clear_stats();
        // R1: idle after reset with no energy stays high
        do_reset(0, 1000);
        repeat (20) @(negedge clk);
        check(n_fall[0] == 0 && n_fall[1] == 0 && n_fall[2] == 0, "R1 no pulses after reset",
              n_fall[0] + n_fall[1] + n_fall[2], 0);

        // R2 / R3: 2500 units at threshold 1000 -> two pulses
        burst(100, 0, 0, 25);
        repeat (3000) @(negedge clk);
        check(n_fall[0] == 2, "R2 pulse count", n_fall[0], 2);
        check(min_w == PW, "R3 min width", min_w, PW);
        check(max_w == PW, "R3 max width", max_w, PW);

        // R4: 5000 units arrive at once -> five pulses exactly one period apart
        do_reset(0, 1000);
        burst(1000, 0, 0, 5);
        repeat (6000) @(negedge clk);
        check(n_fall[0] == 5, "R4 backlog pulses kept", n_fall[0], 5);
        check(min_sp[0] == PER, "R4 spacing at max rate", min_sp[0], PER);

        // R5: negative energy -4000 -> four pulses
        do_reset(0, 1000);
        burst(-400, 0, 0, 10);
        repeat (5000) @(negedge clk);
        check(n_fall[0] == 4, "R5 negative pulses", n_fall[0], 4);

        // R6: apparent pulses on e2 in mode 0
        do_reset(0, 1000);
        burst(0, 500, 0, 4);
        repeat (3000) @(negedge clk);
        check(n_fall[1] == 2, "R6 apparent pulses on e2", n_fall[1], 2);
        check(n_fall[0] == 0, "R6 no active pulses", n_fall[0], 0);

        // R8: active and reactive together
        do_reset(0, 1000);
        burst(1000, 0, 1000, 2);
        repeat (4500) @(negedge clk);
        check(n_fall[0] == 2, "R8 active count", n_fall[0], 2);
        check(n_fall[2] == 2, "R8 reactive count", n_fall[2], 2);
        check(min_e3gap >= LAG, "R8 e3 lag after e1", min_e3gap, LAG);

        // R7: sign mode with a reversal
        do_reset(1, 1000);
        burst(-1000, 0, 0, 2);
        repeat (300) @(negedge clk);
        check(e2_n == 0, "R6 sign level negative", e2_n, 0);
        repeat (2000) @(negedge clk);
        burst(1000, 0, 1000, 3);
        repeat (5000) @(negedge clk);
        check(n_fall[0] == 5, "R7 active count in sign mode", n_fall[0], 5);
        check(min_sgap >= SETUP, "R7 sign settle gap", min_sgap, SETUP);
        check(e2_n == 1, "R6 sign level positive", e2_n, 1);

        // R9: zero threshold never pulses
        do_reset(0, 0);
        burst(1000, 1000, 1000, 5);
        repeat (2000) @(negedge clk);
        check(n_fall[0] + n_fall[1] + n_fall[2] == 0, "R9 zero threshold silent",
              n_fall[0] + n_fall[1] + n_fall[2], 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule